// File: doc/BRIEF.md
# Execution-Lane Power Gating Controller

This block decides, cycle by cycle, how many of a core's functional-unit lanes receive power. The core runs either in a dynamically scheduled (out-of-order) mode that always needs a fixed group of lanes, or in a statically scheduled wide-word mode. In that mode each frame of pre-scheduled words carries its own effective width between one lane and all of them. The controller turns a stream of frame-width announcements, frame-commit and last-word-retire pulses, mode-switch requests and the current mode into a contiguous lane-enable vector. It also gives a readiness flag that tells issue logic when every enabled lane has finished waking up.

The policy is asymmetric. Growth is applied in the cycle after the larger width is announced, so wake-up latency overlaps the tail of the previous frame. Shrinking waits for the commit of the frame still using the wider group. When the core decides to return to out-of-order mode, the lane count is raised at once to the out-of-order floor. It is trimmed back down to that floor only when the last wide-word op has retired.

Top module: `lane_power_ctrl`

## Requirements
- R1: After reset the lowest four lanes are enabled (lane_en = 6'b001111) and lanes_ready is low; lanes_ready rises after three rising clock edges with reset released.
- R2: lane_en is always a thermometer code starting at bit 0: lane i is enabled exactly when i is below the current lane count, and the count is between 1 and 6.
- R3: An announced width (width_in, 3 bits) of 0, or of 7, is treated as 6; values 1 to 6 are taken as given.
- R4: An announced width larger than the current count takes effect on lane_en at the first clock edge that samples width_valid, and any pending reduction is dropped.
- R5: An announced width smaller than the current count leaves lane_en unchanged until the next frame_commit pulse, which then applies it; a later announcement equal to the current count cancels the pending reduction.
- R6: A newer smaller announcement replaces an older pending one; only the newest is applied at frame_commit.
- R7: A to_ooo_req pulse with vliw_mode high raises the count to at least 4 at the next edge, discards any pending reduction, and makes later width announcements and commits have no effect until the drain ends.
- R8: last_word_retire during a drain sets the count to exactly 4 and ends the drain; last_word_retire outside a drain has no effect.
- R9: A to_ooo_req pulse with vliw_mode low has no effect: a following width announcement is still applied.
- R10: A lane becomes usable three cycles after its enable rises; lanes_ready is high only when every enabled lane is usable, so turning lanes on drops it and turning lanes off does not.
- R11: When frame_commit and width_valid arrive in the same cycle, the pending reduction is applied first and the new width is then compared against the reduced count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vliw_mode | input | 1 | High while the core runs pre-scheduled wide words |
| width_valid | input | 1 | Pulse: width_in holds the width of the next frame |
| width_in | input | 3 | Announced frame width (0 and 7 mean all six lanes) |
| frame_commit | input | 1 | Pulse: last word of the preceding frame committed |
| last_word_retire | input | 1 | Pulse: last wide-word op retired after a mode switch |
| to_ooo_req | input | 1 | Pulse: a return to out-of-order mode has been decided |
| lane_en | output | 6 | Per-lane power enable, contiguous from lane 0 |
| lanes_ready | output | 1 | All enabled lanes have completed wake-up |

## Verification
The bench targets the ordering cases. One is a commit and an announcement in the same cycle, where a design that compared against the old count would keep six lanes instead of dropping to four. Another is an announcement equal to the current width, which must cancel a pending cut; a design that forgot it would gate lanes the next frame needs. It also covers a switch request during a pending reduction, which must not later shrink below four, and a retire or switch pulse outside its valid context, which a careless design would act on. Readiness is checked cycle by cycle around growth and shrink, so an off-by-one wake counter or a flag that drops on power-down shows up.

// File: rtl/lane_pwr_pkg.sv
package lane_pwr_pkg;

  // Map a raw width announcement to a legal lane count: 0 or above the
  // lane total means "use every lane".
  function automatic int unsigned clamp_lane_req(input int unsigned raw,
                                                 input int unsigned lanes);
    if (raw == 0 || raw > lanes) return lanes;
    return raw;
  endfunction

  // Larger of two counts; used to apply the out-of-order floor.
  function automatic int unsigned at_least(input int unsigned val,
                                           input int unsigned floor_val);
    return (val < floor_val) ? floor_val : val;
  endfunction

endpackage

// File: rtl/lane_width_tracker.sv
module lane_width_tracker
  import lane_pwr_pkg::*;
#(
  parameter int unsigned NUM_LANES  = 6,
  parameter int unsigned OOO_LANES  = 4,
  parameter int unsigned WIDTH_IN_W = 3,
  parameter int unsigned CNT_W      = $clog2(NUM_LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vliw_mode,
  input  logic                  width_valid,
  input  logic [WIDTH_IN_W-1:0] width_in,
  input  logic                  frame_commit,
  input  logic                  last_word_retire,
  input  logic                  to_ooo_req,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam logic [CNT_W-1:0] OOO_CNT = CNT_W'(OOO_LANES);
  localparam logic [CNT_W-1:0] ALL_CNT = CNT_W'(NUM_LANES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             pend_v_q, pend_v_d;
  logic             drain_q, drain_d;

  logic [CNT_W-1:0] req_w;
  logic [CNT_W-1:0] base_w;
  logic [CNT_W-1:0] floor_w;

  // Named internal events, visible to the assertions below.
  logic commit_apply_evt;
  logic ooo_enter_evt;
  logic ooo_settle_evt;
  logic announce_evt;
  logic grow_evt;
  logic defer_evt;

  assign req_w   = CNT_W'(clamp_lane_req(32'(width_in), NUM_LANES));
  assign floor_w = CNT_W'(at_least(32'(cnt_q), OOO_LANES));

  assign commit_apply_evt = frame_commit && pend_v_q;
  assign base_w           = commit_apply_evt ? pend_q : cnt_q;
  assign ooo_enter_evt    = to_ooo_req && vliw_mode;
  assign ooo_settle_evt   = drain_q && last_word_retire && !ooo_enter_evt;
  assign announce_evt     = width_valid && !drain_q && !ooo_enter_evt;
  assign grow_evt         = announce_evt && (req_w > base_w);
  assign defer_evt        = announce_evt && (req_w < base_w);

  always_comb begin
    cnt_d    = base_w;
    pend_d   = pend_q;
    pend_v_d = pend_v_q && !frame_commit;
    drain_d  = drain_q;
    if (ooo_enter_evt) begin
      cnt_d    = floor_w;
      pend_v_d = 1'b0;
      drain_d  = 1'b1;
    end else if (ooo_settle_evt) begin
      cnt_d    = OOO_CNT;
      pend_v_d = 1'b0;
      drain_d  = 1'b0;
    end else if (announce_evt) begin
      if (defer_evt) begin
        pend_d   = req_w;
        pend_v_d = 1'b1;
      end else begin
        cnt_d    = req_w;
        pend_v_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= OOO_CNT;
      pend_q   <= OOO_CNT;
      pend_v_q <= 1'b0;
      drain_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      drain_q  <= drain_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: count stays within 1..NUM_LANES
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= 1) && (cnt_q <= ALL_CNT));

  // R4: growth lands at the next edge
  p_grow_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grow_evt |=> (cnt_q == $past(req_w)));

  // R5: a smaller width without a commit leaves the count alone
  p_shrink_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_evt && !frame_commit) |=> (cnt_q == $past(cnt_q)));

  // R7: switch request lifts the count to the floor and starts a drain
  p_ooo_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ooo_enter_evt |=> (cnt_q >= OOO_CNT) && drain_q && !pend_v_q);

  // R7: nothing but a switch or a retire moves the count during a drain
  p_drain_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && !last_word_retire && !ooo_enter_evt) |=> $stable(cnt_q));

  // R8: retire during a drain settles at exactly the floor
  p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ooo_settle_evt |=> (cnt_q == OOO_CNT) && !drain_q);

  // R9: a switch request outside wide-word mode starts no drain
  p_mode_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (to_ooo_req && !vliw_mode && !drain_q) |=> !drain_q);

endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen #(
  parameter int unsigned NUM_LANES = 6,
  parameter int unsigned CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic [CNT_W-1:0]     cnt,
  output logic [NUM_LANES-1:0] mask
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign mask[g] = (cnt > CNT_W'(g));
  end
endmodule

// File: rtl/lane_wake_cell.sv
module lane_wake_cell #(
  parameter int unsigned WAKE_CYCLES = 3,
  parameter int unsigned WK_W        = $clog2(WAKE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic usable
);
  localparam logic [WK_W-1:0] WK_MAX = WK_W'(WAKE_CYCLES);

  logic [WK_W-1:0] wk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wk_q <= '0;
    else if (!en)           wk_q <= '0;
    else if (wk_q < WK_MAX) wk_q <= wk_q + 1'b1;
  end

  assign usable = en && (wk_q == WK_MAX);

  // R10: an unpowered lane is never reported usable one cycle later
  p_off_not_usable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (wk_q == '0) || en == 1'b1 && wk_q <= WK_W'(1));
endmodule

// File: rtl/lane_power_ctrl.sv
module lane_power_ctrl #(
  parameter int unsigned NUM_LANES   = 6,
  parameter int unsigned OOO_LANES   = 4,
  parameter int unsigned WAKE_CYCLES = 3,
  parameter int unsigned WIDTH_IN_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vliw_mode,
  input  logic                  width_valid,
  input  logic [WIDTH_IN_W-1:0] width_in,
  input  logic                  frame_commit,
  input  logic                  last_word_retire,
  input  logic                  to_ooo_req,
  output logic [NUM_LANES-1:0]  lane_en,
  output logic                  lanes_ready
);
  localparam int unsigned CNT_W = $clog2(NUM_LANES + 1);
  localparam int unsigned WK_W  = $clog2(WAKE_CYCLES + 1);

  logic [CNT_W-1:0]     lane_cnt;
  logic [NUM_LANES-1:0] lane_usable;
  logic [NUM_LANES:0]   en_ext;

  lane_width_tracker #(
    .NUM_LANES (NUM_LANES),
    .OOO_LANES (OOO_LANES),
    .WIDTH_IN_W(WIDTH_IN_W),
    .CNT_W     (CNT_W)
  ) u_tracker (
    .clk             (clk),
    .rst_n           (rst_n),
    .vliw_mode       (vliw_mode),
    .width_valid     (width_valid),
    .width_in        (width_in),
    .frame_commit    (frame_commit),
    .last_word_retire(last_word_retire),
    .to_ooo_req      (to_ooo_req),
    .cnt_o           (lane_cnt)
  );

  lane_mask_gen #(
    .NUM_LANES(NUM_LANES),
    .CNT_W    (CNT_W)
  ) u_mask (
    .cnt (lane_cnt),
    .mask(lane_en)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_wake
    lane_wake_cell #(
      .WAKE_CYCLES(WAKE_CYCLES),
      .WK_W       (WK_W)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (lane_en[g]),
      .usable(lane_usable[g])
    );
  end

  assign lanes_ready = &(~lane_en | lane_usable);
  assign en_ext      = {1'b0, lane_en};

  // R2: enabled lanes form one block starting at lane 0
  p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((en_ext + 1'b1) & en_ext) == '0) && lane_en[0]);

  // R10: any lane that just powered up holds readiness low
  p_wake_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lane_en & ~$past(lane_en))) |-> !lanes_ready);

endmodule

// File: tb/lane_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module lane_power_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vliw_mode = 1'b0;
  logic       width_valid = 1'b0;
  logic [2:0] width_in = 3'd0;
  logic       frame_commit = 1'b0;
  logic       last_word_retire = 1'b0;
  logic       to_ooo_req = 1'b0;
  logic [5:0] lane_en;
  logic       lanes_ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  lane_power_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .vliw_mode(vliw_mode),
    .width_valid(width_valid), .width_in(width_in),
    .frame_commit(frame_commit), .last_word_retire(last_word_retire),
    .to_ooo_req(to_ooo_req), .lane_en(lane_en), .lanes_ready(lanes_ready)
  );

  task automatic chk_en(input string req, input logic [5:0] exp);
    n_checks++;
    if (lane_en !== exp) begin
      n_fail++;
      $display("FAIL %s lane_en act=%b exp=%b", req, lane_en, exp);
    end
  endtask

  task automatic chk_rdy(input string req, input logic exp);
    n_checks++;
    if (lanes_ready !== exp) begin
      n_fail++;
      $display("FAIL %s lanes_ready act=%b exp=%b", req, lanes_ready, exp);
    end
  endtask

  // All drive tasks start and end at a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic announce(input logic [2:0] w, input logic commit);
    width_valid = 1'b1; width_in = w; frame_commit = commit;
    @(negedge clk);
    width_valid = 1'b0; frame_commit = 1'b0;
  endtask

  task automatic commit_pulse();
    frame_commit = 1'b1; @(negedge clk); frame_commit = 1'b0;
  endtask

  task automatic switch_pulse();
    to_ooo_req = 1'b1; @(negedge clk); to_ooo_req = 1'b0;
  endtask

  task automatic retire_pulse();
    last_word_retire = 1'b1; @(negedge clk); last_word_retire = 1'b0;
  endtask

  task automatic t_reset();
    chk_en("R1", 6'b001111);
    chk_rdy("R1", 1'b0);
    idle(2); chk_rdy("R1", 1'b0);
    idle(1); chk_rdy("R1", 1'b1);
  endtask

  task automatic t_grow();
    vliw_mode = 1'b1;
    announce(3'd6, 1'b0);
    chk_en("R4", 6'b111111);
    chk_rdy("R10", 1'b0);
    idle(2); chk_rdy("R10", 1'b0);
    idle(1); chk_rdy("R10", 1'b1);
  endtask

  task automatic t_shrink();
    announce(3'd2, 1'b0); chk_en("R5", 6'b111111);
    idle(1);              chk_en("R5", 6'b111111);
    commit_pulse();       chk_en("R5", 6'b000011);
    chk_rdy("R10", 1'b1);
  endtask

  task automatic t_equal_cancel();
    announce(3'd5, 1'b0); chk_en("R4", 6'b011111);
    announce(3'd3, 1'b0); chk_en("R5", 6'b011111);
    announce(3'd5, 1'b0); chk_en("R5", 6'b011111);
    commit_pulse();       chk_en("R5", 6'b011111);
  endtask

  task automatic t_replace();
    announce(3'd1, 1'b0); chk_en("R6", 6'b011111);
    announce(3'd3, 1'b0); chk_en("R6", 6'b011111);
    commit_pulse();       chk_en("R6", 6'b000111);
  endtask

  task automatic t_saturate();
    announce(3'd0, 1'b0); chk_en("R3", 6'b111111);
    announce(3'd1, 1'b0);
    commit_pulse();       chk_en("R3", 6'b000001);
    announce(3'd7, 1'b0); chk_en("R3", 6'b111111);
  endtask

  task automatic t_same_cycle();
    announce(3'd2, 1'b0); chk_en("R11", 6'b111111);
    announce(3'd4, 1'b1); chk_en("R11", 6'b001111);
  endtask

  task automatic t_ooo_switch();
    announce(3'd2, 1'b0);
    commit_pulse();       chk_en("R7", 6'b000011);
    idle(3);
    announce(3'd1, 1'b0); chk_en("R7", 6'b000011);
    switch_pulse();       chk_en("R7", 6'b001111);
    chk_rdy("R10", 1'b0);
    commit_pulse();       chk_en("R7", 6'b001111);
    announce(3'd6, 1'b0); chk_en("R7", 6'b001111);
    retire_pulse();       chk_en("R8", 6'b001111);
    announce(3'd6, 1'b0); chk_en("R8", 6'b111111);
    switch_pulse();       chk_en("R7", 6'b111111);
    retire_pulse();       chk_en("R8", 6'b001111);
  endtask

  task automatic t_mode_ignore();
    vliw_mode = 1'b0;
    switch_pulse();       chk_en("R9", 6'b001111);
    announce(3'd6, 1'b0); chk_en("R9", 6'b111111);
    retire_pulse();       chk_en("R8", 6'b111111);
    announce(3'd4, 1'b0);
    commit_pulse();       chk_en("R5", 6'b001111);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_grow();
    t_shrink();
    t_equal_cancel();
    t_replace();
    t_saturate();
    t_same_cycle();
    t_ooo_switch();
    t_mode_ignore();
    idle(2);
    finish_run();
  end
endmodule